// File: doc/BRIEF.md
# Affine Background Texture Address Generator

This block serves a background layer that can be rotated and scaled. For every screen pixel it works out where that pixel falls in texture space and which bytes of the layer's graphics describe it. The mapping is a 2x2 matrix applied to the screen position, offset by a reference point. It is computed one step at a time, with no multiplier. Each next-pixel strobe adds the signed 8.8 horizontal steps to a pair of running 20.8 accumulators. Each start-of-line strobe reloads the accumulators from an internal line reference. That line reference then advances by the vertical steps, ready for the following line.

The integer part of the accumulated coordinate selects a position in a square map. The map side is 128, 256, 512 or 1024 pixels and is built from 8x8 tiles. The block outputs the byte index of the map entry that covers the pixel and the byte offset of the pixel inside its 8-bit-per-pixel tile. When a coordinate leaves the map, one input picks the result: the coordinate either wraps around the map, or the pixel is marked transparent. Memory reads, palette lookup and layer mixing belong to other blocks.

Top module: `affine_bg_addr_gen`

## Requirements
- R1: After reset the reference registers, the line references and the accumulators are all zero, so `map_addr` is 0, `pix_ofs` is 0 and `transparent` is 0 (with `wrap_en` low and `map_size` 0).
- R2: When `pix_next` is high and `line_start` is low, the X accumulator gains `step_hx` and the Y accumulator gains `step_hy` at the clock edge. Both steps are signed 8.8 values, sign-extended to 28 bits. When both strobes are high, `line_start` wins.
- R3: When `line_start` is high, each accumulator loads its axis line reference. At the same edge, that line reference gains the axis vertical step (`step_vx` for X, `step_vy` for Y).
- R4: A write with `ref_wr_en` high updates one half of a 28-bit signed 20.8 reference. Select 0 loads X bits 15:0 from `ref_wr_data`. Select 1 loads X bits 27:16 from `ref_wr_data[11:0]`, and data bits 15:12 are ignored. Selects 2 and 3 do the same for Y. At the same edge, the line reference of that axis takes the full new reference value, and this overrides any vertical advance. The accumulators are not changed by a write.
- R5: The integer texture coordinate is the accumulator shifted arithmetically right by 8, which rounds towards minus infinity. The map side is 128 shifted left by `map_size`. With tx and ty taken modulo the side, `map_addr` = (ty/8)*(side/8) + tx/8 and `pix_ofs` = (ty mod 8)*8 + (tx mod 8).
- R6: With `wrap_en` high, coordinates outside the map wrap modulo the side and `transparent` stays low.
- R7: With `wrap_en` low, `transparent` is high exactly when tx or ty is negative or not less than the side. In that case `map_addr` and `pix_ofs` still follow R5.
- R8: In a cycle with no strobe and no write, the accumulators and line references hold, so the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_hx | input | 16 | Signed 8.8 X change per pixel |
| step_vx | input | 16 | Signed 8.8 X change per line |
| step_hy | input | 16 | Signed 8.8 Y change per pixel |
| step_vy | input | 16 | Signed 8.8 Y change per line |
| ref_wr_en | input | 1 | Write one half of a reference register |
| ref_wr_sel | input | 2 | 0 X low, 1 X high, 2 Y low, 3 Y high |
| ref_wr_data | input | 16 | Data for the selected half |
| map_size | input | 2 | Map side = 128 << map_size pixels |
| wrap_en | input | 1 | 1: wrap out-of-map coordinates, 0: mark them transparent |
| line_start | input | 1 | Start-of-line strobe from raster timing |
| pix_next | input | 1 | Advance-one-pixel strobe from raster timing |
| map_addr | output | 14 | Byte index of the map entry covering the pixel |
| pix_ofs | output | 6 | Byte offset of the pixel inside its tile |
| transparent | output | 1 | Pixel lies outside the map while wrapping is off |

## Verification
Map edges at large sizes, and coordinates below zero, are the hardest situations to reach from the ports. Walking there with pixel steps alone would take hundreds of strobes per line. The stimulus instead jumps there by writing both halves of the reference registers, including negative high halves. From there, small positive and negative steps carry the coordinate across 0 and across the side, with wrapping switched on and off in turn. The bench also writes a reference between line starts, after the line reference has already advanced, so that the override of R4 shows up in the next line's first address.

// File: rtl/affine_pkg.sv
package affine_pkg;
  parameter int COORD_W       = 28;
  parameter int FRAC_W        = 8;
  parameter int STEP_W        = 16;
  parameter int HALF_W        = 16;
  parameter int SIZE_W        = 2;
  parameter int MIN_SIDE_LOG2 = 7;
  parameter int TILE_LOG2     = 3;

  localparam int INT_W         = COORD_W - FRAC_W;
  localparam int HI_W          = COORD_W - HALF_W;
  localparam int MAX_SIDE_LOG2 = MIN_SIDE_LOG2 + (1 << SIZE_W) - 1;
  localparam int CELL_W        = MAX_SIDE_LOG2 - TILE_LOG2;
  localparam int CELL_MIN_LOG2 = MIN_SIDE_LOG2 - TILE_LOG2;
  localparam int ADDR_W        = 2 * CELL_W;
  localparam int OFS_W         = 2 * TILE_LOG2;

  typedef enum logic [1:0] {
    SEL_X_LO = 2'd0,
    SEL_X_HI = 2'd1,
    SEL_Y_LO = 2'd2,
    SEL_Y_HI = 2'd3
  } ref_sel_e;

  typedef logic signed [COORD_W-1:0] coord_t;
  typedef logic signed [INT_W-1:0]   icoord_t;

  // Sign-extend an 8.8 step to the accumulator width.
  function automatic coord_t widen_step(input logic [STEP_W-1:0] s);
    return coord_t'($signed(s));
  endfunction

  // Mask that keeps a coordinate inside a map of the chosen size.
  function automatic logic [MAX_SIDE_LOG2-1:0] side_mask(input logic [SIZE_W-1:0] sz);
    return MAX_SIDE_LOG2'((1 << (MIN_SIDE_LOG2 + int'(sz))) - 1);
  endfunction

  // True when an integer coordinate lies within [0, side).
  function automatic logic axis_inside(input icoord_t c, input logic [SIZE_W-1:0] sz);
    icoord_t lim;
    lim = icoord_t'(1) <<< (MIN_SIDE_LOG2 + int'(sz));
    return (c >= 0) && (c < lim);
  endfunction

  // Row-major tile cell index: row * tiles_per_row + col.
  function automatic logic [ADDR_W-1:0] cell_index(input logic [CELL_W-1:0] row,
                                                   input logic [CELL_W-1:0] col,
                                                   input logic [SIZE_W-1:0] sz);
    return (ADDR_W'(row) << (CELL_MIN_LOG2 + int'(sz))) | ADDR_W'(col);
  endfunction
endpackage

// File: rtl/affine_axis.sv
module affine_axis
  import affine_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [STEP_W-1:0] h_step,
  input  logic [STEP_W-1:0] v_step,
  input  logic              line_start,
  input  logic              pix_next,
  output coord_t            acc_q,
  output coord_t            line_ref_q
);
  coord_t ref_q;
  coord_t ref_d;
  logic   ref_wr;
  logic [HALF_W-HI_W-1:0] unused_hi_bits;

  assign unused_hi_bits = wr_data[HALF_W-1:HI_W];
  assign ref_wr         = wr_lo | wr_hi;

  always_comb begin
    ref_d = ref_q;
    if (wr_lo) ref_d[HALF_W-1:0]       = wr_data;
    if (wr_hi) ref_d[COORD_W-1:HALF_W] = wr_data[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q      <= '0;
      line_ref_q <= '0;
      acc_q      <= '0;
    end else begin
      ref_q <= ref_d;
      if (ref_wr)
        line_ref_q <= ref_d;
      else if (line_start)
        line_ref_q <= line_ref_q + widen_step(v_step);
      if (line_start)
        acc_q <= line_ref_q;
      else if (pix_next)
        acc_q <= acc_q + widen_step(h_step);
    end
  end
endmodule

// File: rtl/affine_map_decode.sv
module affine_map_decode
  import affine_pkg::*;
(
  input  icoord_t           ix,
  input  icoord_t           iy,
  input  logic [SIZE_W-1:0] map_size,
  input  logic              wrap_en,
  output logic [ADDR_W-1:0] map_addr,
  output logic [OFS_W-1:0]  pix_ofs,
  output logic              transparent,
  output logic              x_inside,
  output logic              y_inside
);
  logic [MAX_SIDE_LOG2-1:0] wx;
  logic [MAX_SIDE_LOG2-1:0] wy;

  assign wx = ix[MAX_SIDE_LOG2-1:0] & side_mask(map_size);
  assign wy = iy[MAX_SIDE_LOG2-1:0] & side_mask(map_size);

  assign x_inside = axis_inside(ix, map_size);
  assign y_inside = axis_inside(iy, map_size);

  assign map_addr    = cell_index(wy[MAX_SIDE_LOG2-1:TILE_LOG2],
                                  wx[MAX_SIDE_LOG2-1:TILE_LOG2], map_size);
  assign pix_ofs     = {wy[TILE_LOG2-1:0], wx[TILE_LOG2-1:0]};
  assign transparent = !wrap_en && !(x_inside && y_inside);
endmodule

// File: rtl/affine_bg_addr_gen.sv
module affine_bg_addr_gen
  import affine_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step_hx,
  input  logic [STEP_W-1:0] step_vx,
  input  logic [STEP_W-1:0] step_hy,
  input  logic [STEP_W-1:0] step_vy,
  input  logic              ref_wr_en,
  input  logic [1:0]        ref_wr_sel,
  input  logic [HALF_W-1:0] ref_wr_data,
  input  logic [SIZE_W-1:0] map_size,
  input  logic              wrap_en,
  input  logic              line_start,
  input  logic              pix_next,
  output logic [ADDR_W-1:0] map_addr,
  output logic [OFS_W-1:0]  pix_ofs,
  output logic              transparent
);
  localparam int NAXES = 2;

  logic [STEP_W-1:0] h_step  [NAXES];
  logic [STEP_W-1:0] v_step  [NAXES];
  logic              wr_lo   [NAXES];
  logic              wr_hi   [NAXES];
  coord_t            acc_q   [NAXES];
  coord_t            lref_q  [NAXES];

  // Named internal events and state for the checker
  coord_t acc_x, acc_y, lref_x, lref_y;
  logic   x_inside, y_inside;

  assign h_step[0] = step_hx;
  assign h_step[1] = step_hy;
  assign v_step[0] = step_vx;
  assign v_step[1] = step_vy;

  assign wr_lo[0] = ref_wr_en && (ref_wr_sel == SEL_X_LO);
  assign wr_hi[0] = ref_wr_en && (ref_wr_sel == SEL_X_HI);
  assign wr_lo[1] = ref_wr_en && (ref_wr_sel == SEL_Y_LO);
  assign wr_hi[1] = ref_wr_en && (ref_wr_sel == SEL_Y_HI);

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    affine_axis u_axis (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_lo      (wr_lo[a]),
      .wr_hi      (wr_hi[a]),
      .wr_data    (ref_wr_data),
      .h_step     (h_step[a]),
      .v_step     (v_step[a]),
      .line_start (line_start),
      .pix_next   (pix_next),
      .acc_q      (acc_q[a]),
      .line_ref_q (lref_q[a])
    );
  end

  assign acc_x  = acc_q[0];
  assign acc_y  = acc_q[1];
  assign lref_x = lref_q[0];
  assign lref_y = lref_q[1];

  affine_map_decode u_decode (
    .ix          (acc_x[COORD_W-1:FRAC_W]),
    .iy          (acc_y[COORD_W-1:FRAC_W]),
    .map_size    (map_size),
    .wrap_en     (wrap_en),
    .map_addr    (map_addr),
    .pix_ofs     (pix_ofs),
    .transparent (transparent),
    .x_inside    (x_inside),
    .y_inside    (y_inside)
  );
endmodule

// File: rtl/affine_bg_checker.sv
module affine_bg_checker
  import affine_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [STEP_W-1:0] step_hx,
  input logic [STEP_W-1:0] step_vx,
  input logic [STEP_W-1:0] step_hy,
  input logic [STEP_W-1:0] step_vy,
  input logic              ref_wr_en,
  input logic [1:0]        ref_wr_sel,
  input logic [HALF_W-1:0] ref_wr_data,
  input logic [SIZE_W-1:0] map_size,
  input logic              wrap_en,
  input logic              line_start,
  input logic              pix_next,
  input logic [ADDR_W-1:0] map_addr,
  input logic              transparent,
  input coord_t            acc_x,
  input coord_t            acc_y,
  input coord_t            lref_x,
  input coord_t            lref_y
);
  AST_LINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (acc_x == $past(lref_x)) && (acc_y == $past(lref_y))); // R3

  AST_VERT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !ref_wr_en) |=>
      (lref_x == coord_t'($past(lref_x) + widen_step($past(step_vx)))) &&
      (lref_y == coord_t'($past(lref_y) + widen_step($past(step_vy))))); // R3

  AST_PIXEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_next && !line_start) |=>
      (acc_x == coord_t'($past(acc_x) + widen_step($past(step_hx)))) &&
      (acc_y == coord_t'($past(acc_y) + widen_step($past(step_hy))))); // R2

  AST_REF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_wr_en && ref_wr_sel == 2'd0) |=> (lref_x[HALF_W-1:0] == $past(ref_wr_data))); // R4

  AST_WRITE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_wr_en && !line_start && !pix_next) |=> $stable(acc_x) && $stable(acc_y)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !pix_next && !ref_wr_en) |=>
      $stable(acc_x) && $stable(acc_y) && $stable(lref_x) && $stable(lref_y)); // R8

  AST_WRAP_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_en |-> !transparent); // R6

  AST_NEG_TRANSP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_en && (acc_x < 0 || acc_y < 0)) |-> transparent); // R7

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(map_addr) >> (2 * (CELL_MIN_LOG2 + int'(map_size)))) == 0)); // R5
endmodule

bind affine_bg_addr_gen affine_bg_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_hx     (step_hx),
  .step_vx     (step_vx),
  .step_hy     (step_hy),
  .step_vy     (step_vy),
  .ref_wr_en   (ref_wr_en),
  .ref_wr_sel  (ref_wr_sel),
  .ref_wr_data (ref_wr_data),
  .map_size    (map_size),
  .wrap_en     (wrap_en),
  .line_start  (line_start),
  .pix_next    (pix_next),
  .map_addr    (map_addr),
  .transparent (transparent),
  .acc_x       (acc_x),
  .acc_y       (acc_y),
  .lref_x      (lref_x),
  .lref_y      (lref_y)
);

// File: tb/affine_bg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module affine_bg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] step_hx = '0, step_vx = '0, step_hy = '0, step_vy = '0;
  logic        ref_wr_en = 1'b0;
  logic [1:0]  ref_wr_sel = '0;
  logic [15:0] ref_wr_data = '0;
  logic [1:0]  map_size = '0;
  logic        wrap_en = 1'b0;
  logic        line_start = 1'b0;
  logic        pix_next = 1'b0;
  logic [13:0] map_addr;
  logic [5:0]  pix_ofs;
  logic        transparent;

  always #2 clk = ~clk;

  affine_bg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .step_hx(step_hx), .step_vx(step_vx), .step_hy(step_hy), .step_vy(step_vy),
    .ref_wr_en(ref_wr_en), .ref_wr_sel(ref_wr_sel), .ref_wr_data(ref_wr_data),
    .map_size(map_size), .wrap_en(wrap_en),
    .line_start(line_start), .pix_next(pix_next),
    .map_addr(map_addr), .pix_ofs(pix_ofs), .transparent(transparent)
  );

  typedef struct {
    logic [13:0] addr;
    logic [5:0]  ofs;
    logic        tr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  // Bench-side model state (28-bit signed 20.8)
  logic signed [27:0] m_ref [2];
  logic signed [27:0] m_lref[2];
  logic signed [27:0] m_acc [2];

  function automatic longint floor_mod(input longint v, input longint m);
    longint r;
    r = v % m;
    if (r < 0) r += m;
    return r;
  endfunction

  task automatic expect_now(input string tag);
    longint tx, ty, side, mx, my;
    exp_t e;
    tx   = longint'(m_acc[0]) >>> 8;
    ty   = longint'(m_acc[1]) >>> 8;
    side = longint'(128) << map_size;
    mx   = floor_mod(tx, side);
    my   = floor_mod(ty, side);
    e.addr = 14'((my / 8) * (side / 8) + (mx / 8));
    e.ofs  = 6'((my % 8) * 8 + (mx % 8));
    e.tr   = !wrap_en && (tx < 0 || tx >= side || ty < 0 || ty >= side);
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic strobe(input logic ls, input logic pn, input string tag);
    @(negedge clk); #1;
    line_start = ls; pix_next = pn;
    @(posedge clk); #1;
    line_start = 1'b0; pix_next = 1'b0;
    if (ls) begin
      m_acc[0]  = m_lref[0];
      m_acc[1]  = m_lref[1];
      m_lref[0] = m_lref[0] + $signed(step_vx);
      m_lref[1] = m_lref[1] + $signed(step_vy);
    end else if (pn) begin
      m_acc[0] = m_acc[0] + $signed(step_hx);
      m_acc[1] = m_acc[1] + $signed(step_hy);
    end
    expect_now(tag);
  endtask

  task automatic write_ref(input logic [1:0] sel, input logic [15:0] data, input string tag);
    int ax;
    @(negedge clk); #1;
    ref_wr_en = 1'b1; ref_wr_sel = sel; ref_wr_data = data;
    @(posedge clk); #1;
    ref_wr_en = 1'b0;
    ax = int'(sel[1]);
    if (sel[0]) m_ref[ax][27:16] = data[11:0];
    else        m_ref[ax][15:0]  = data;
    m_lref[ax] = m_ref[ax];
    expect_now(tag);
  endtask

  task automatic set_cfg(input logic [1:0] sz, input logic wr, input string tag);
    @(negedge clk); #1;
    map_size = sz; wrap_en = wr;
    expect_now(tag);
  endtask

  task automatic set_steps(input logic [15:0] hx, input logic [15:0] vx,
                           input logic [15:0] hy, input logic [15:0] vy);
    @(negedge clk); #1;
    step_hx = hx; step_vx = vx; step_hy = hy; step_vy = vy;
  endtask

  task automatic print_summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (map_addr !== e.addr || pix_ofs !== e.ofs || transparent !== e.tr) begin
        errors++;
        $display("FAIL %s: actual addr=%0d ofs=%0d tr=%0b expected addr=%0d ofs=%0d tr=%0b",
                 e.tag, map_addr, pix_ofs, transparent, e.addr, e.ofs, e.tr);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual=timeout expected=completion");
      print_summary();
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 2; a++) begin
      m_ref[a] = '0; m_lref[a] = '0; m_acc[a] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;
    expect_now("R1 reset state");

    // Identity matrix, small map, no wrap
    set_steps(16'h0100, 16'h0000, 16'h0000, 16'h0100);
    write_ref(2'd0, 16'h0500, "R4 write X low keeps accumulator");
    write_ref(2'd2, 16'h0A00, "R4 write Y low keeps accumulator");
    strobe(1'b1, 1'b0, "R3 line start loads reference");
    for (int i = 0; i < 4; i++) strobe(1'b0, 1'b1, "R2 unit pixel step");
    strobe(1'b0, 1'b0, "R8 idle cycle holds");
    strobe(1'b1, 1'b0, "R3 line reference advanced by vertical step");
    strobe(1'b1, 1'b1, "R2 line start wins over pixel step");

    // Fractional step
    set_steps(16'h0080, 16'h0000, 16'h0000, 16'h0100);
    for (int i = 0; i < 5; i++) strobe(1'b0, 1'b1, "R5 half-pixel step floor");

    // Negative step crossing zero: transparent, then wrapped
    set_steps(16'hFF00, 16'h0000, 16'h0000, 16'h0100);
    for (int i = 0; i < 10; i++) strobe(1'b0, 1'b1, "R7 negative walk");
    set_cfg(2'd0, 1'b1, "R6 wrap of negative coordinate");
    strobe(1'b0, 1'b1, "R6 wrap after further step");
    set_cfg(2'd0, 1'b0, "R7 transparent again without wrap");

    // Large coordinates in each map size
    write_ref(2'd0, 16'hBC00, "R4 X low large");
    write_ref(2'd1, 16'hF002, "R4 X high ignores bits 15:12");
    write_ref(2'd2, 16'h8400, "R4 Y low large");
    write_ref(2'd3, 16'h0003, "R4 Y high");
    strobe(1'b1, 1'b0, "R3 load large reference");
    for (int s = 0; s < 4; s++) begin
      set_cfg(2'(s), 1'b0, "R7 size sweep no wrap");
      set_cfg(2'(s), 1'b1, "R6 size sweep wrap");
    end
    set_cfg(2'd3, 1'b0, "R5 largest map in range");
    set_steps(16'h0100, 16'h0000, 16'h0000, 16'h0100);
    for (int i = 0; i < 330; i++) strobe(1'b0, 1'b1, "R7 walk past largest side");

    // Reference write overrides advanced line reference
    strobe(1'b1, 1'b0, "R3 line start");
    strobe(1'b1, 1'b0, "R3 line start again");
    write_ref(2'd3, 16'h0000, "R4 Y high clear");
    write_ref(2'd2, 16'h1234, "R4 Y low override");
    write_ref(2'd1, 16'h0000, "R4 X high clear");
    write_ref(2'd0, 16'h2A80, "R4 X low override");
    strobe(1'b1, 1'b0, "R4 next line uses written reference");

    // Rotation-like matrix with negative components
    set_steps(16'h00E0, 16'hFFC0, 16'h0040, 16'h00E0);
    set_cfg(2'd1, 1'b0, "R5 map size 1");
    for (int ln = 0; ln < 3; ln++) begin
      strobe(1'b1, 1'b0, "R3 rotated line start");
      for (int i = 0; i < 12; i++) strobe(1'b0, 1'b1, "R2 rotated pixel walk");
    end

    // Negative high half: far negative coordinate
    write_ref(2'd1, 16'h0FFF, "R4 negative X high");
    strobe(1'b1, 1'b0, "R7 negative reference transparent");
    set_cfg(2'd2, 1'b1, "R6 negative reference wrapped");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk); #1;
    done = 1'b1;
    print_summary();
    $finish;
  end
endmodule